// File: doc/BRIEF.md
# Rotating Address-Sliced Shared Memory Arbiter

This block lets sixteen cores share one word-addressed memory without a central grant queue. The memory is cut into sixteen banks, and the bank that holds a word is given by the four least significant bits of its word address. A free-running rotation counter steps once per clock. At any moment each core is wired to exactly one bank, and no two cores are wired to the same bank. A core raises a request and holds it steady. The access happens in the cycle when the rotation brings that core to the bank that holds its address. In that cycle the block raises a one-cycle completion strobe, and for reads it registers the data at the closing clock edge.

The wait therefore depends on where the target word lies relative to the current rotation. Walking consecutive addresses costs no waiting at all, because the next bank arrives exactly one clock later. A parameter selects a fixed-slot variant for comparison. In that variant each core owns one cycle in sixteen and may reach any bank in that cycle.

Top module: `hub_rotary_xbar`

## Requirements
- R1: While `rst_n` is low (sampled at the clock edge), the rotation counter returns to zero, every `done` bit is low whatever the request inputs are, no write takes place and every `rdata` lane reads zero. In the first cycle after release the rotation value is 0.
- R2: The bank of an address is `addr[3:0]`. In the address-sliced mode, with rotation value r (r = number of clock edges since reset release, modulo 16), core c is joined to bank (c + r) mod 16. `done[c]` is high in exactly the cycles where `req_valid[c]` is high and the request's bank equals that value. A request issued at rotation r therefore waits (bank − c − r) mod 16 cycles.
- R3: No two `done` strobes in the same cycle belong to requests that target the same bank.
- R4: In the address-sliced mode, if a core's access to bank 1 completes and the core at once requests bank 5, the second `done` comes 4 clocks after the first. From bank 2 to bank 12 the gap is 10 clocks.
- R5: In the address-sliced mode, a core that presents address A+1 in the cycle right after its access to A completes gets `done` in that same cycle, so a run of consecutive addresses moves one word per clock, including across the wrap from bank 15 to bank 0.
- R6: For a read, `rdata` lane c is loaded at the clock edge that ends the `done[c]` cycle, is visible from the next cycle on, and keeps its value until core c completes another read.
- R7: On a write, bit i of the core's 4-bit byte-enable field selects data bits 8i+7..8i. Bytes whose enable bit is 0 keep their old contents, and an all-zero mask changes nothing.
- R8: With `MODE` set to the fixed-slot variant, core c completes only in cycles where the rotation value equals c, whatever its address. At most one `done` bit is high per cycle, so back-to-back accesses by one core are 16 clocks apart.
- R9: A word written by any core reads back with the same value through any other core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_CORES | Per-core request, held until `done` |
| req_we | input | N_CORES | Per-core write (1) or read (0) |
| req_addr | input | N_CORES*ADDR_W | Per-core word address, core c at bits c*ADDR_W upward |
| req_wdata | input | N_CORES*DATA_W | Per-core write data |
| req_be | input | N_CORES*DATA_W/8 | Per-core byte-enable mask |
| done | output | N_CORES | Per-core completion strobe, one cycle |
| rdata | output | N_CORES*DATA_W | Per-core registered read data |

## Verification
The bench predicts each wait from its own rotation count and compares it with the cycle in which `done` appears. A crossbar that rotated the wrong way, or started at a nonzero phase, would get every latency wrong. The 1→5 and 2→12 gaps and a consecutive-address run that crosses bank 15 into bank 0 expose a design that waits for a full turn or mishandles the wrap. Sixteen cores aimed at one bank at the same time must finish one per cycle within a single turn; a faulty mux would pair two cores with one bank or leave a core stranded. Partial and empty byte masks, data shared between cores, and the fixed-slot variant's address-blind 16-cycle spacing are each checked against values written earlier.

// File: rtl/hub_pkg.sv
// Shared definitions for the rotating hub arbiter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package hub_pkg;

    // Arbitration variant selected at elaboration time.
    typedef enum logic {
        HUB_SLICED = 1'b0,   // core meets the bank that holds its address
        HUB_SLOT   = 1'b1    // core owns one cycle of the turn, any bank
    } hub_mode_e;

endpackage

// File: rtl/hub_rotor.sv
// Rotation counter: advances by one every clock, wraps at 2**SEL_W.
// Assumes a synchronous active-low reset that clears it to zero.
module hub_rotor #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SEL_W-1:0] rot
);

    // Step the rotation once per clock, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rot <= '0;
        else        rot <= rot + 1'b1;
    end

endmodule

// File: rtl/hub_grant.sv
// Per-core alignment check: tells a core that this cycle it may access.
// Sliced mode: aligned when the target bank equals (core id + rotation).
// Slot mode: aligned when the rotation equals the core id.
// Assumes requests are held stable until the strobe.
module hub_grant #(
    parameter int                 SEL_W   = 4,
    parameter int                 CORE_ID = 0,
    parameter hub_pkg::hub_mode_e MODE    = hub_pkg::HUB_SLICED
) (
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rot,
    input  logic             req,
    input  logic [SEL_W-1:0] bank_sel,
    output logic             done
);

    localparam logic [SEL_W-1:0] ID = SEL_W'(CORE_ID);

    logic [SEL_W-1:0] facing;
    logic             aligned;

    // Work out which bank faces this core and whether the request may go.
    always_comb begin
        facing = ID + rot;
        if (MODE == hub_pkg::HUB_SLICED) aligned = (bank_sel == facing);
        else                             aligned = (rot == ID);
        done = rst_n && req && aligned;
    end

endmodule

// File: rtl/hub_bank.sv
// One memory bank: register array, combinational read of the selected
// row, byte-masked synchronous write. Contents are not reset.
module hub_bank #(
    parameter int ROW_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [DATA_W/8-1:0] be,
    input  logic [ROW_W-1:0]    row,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int ROWS = 1 << ROW_W;
    localparam int BE_W = DATA_W / 8;

    logic [DATA_W-1:0] mem [ROWS];

    // Write the enabled bytes of the selected row.
    always_ff @(posedge clk) begin
        for (int i = 0; i < BE_W; i++) begin
            if (wr_en && be[i]) mem[row][i*8 +: 8] <= wdata[i*8 +: 8];
        end
    end

    // Present the selected row for a read.
    assign rd_data = mem[row];

endmodule

// File: rtl/hub_rotary_xbar.sv
// Rotating crossbar between N_CORES cores and N_CORES memory banks.
// The bank of a word is its low SEL_W address bits; the remaining bits
// pick the row inside the bank. Assumes N_CORES is a power of two and
// that each core holds its request stable until its done strobe.
module hub_rotary_xbar #(
    parameter int                 N_CORES = 16,
    parameter int                 ADDR_W  = 10,
    parameter int                 DATA_W  = 32,
    parameter hub_pkg::hub_mode_e MODE    = hub_pkg::HUB_SLICED
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_CORES-1:0]             req_valid,
    input  logic [N_CORES-1:0]             req_we,
    input  logic [N_CORES*ADDR_W-1:0]      req_addr,
    input  logic [N_CORES*DATA_W-1:0]      req_wdata,
    input  logic [N_CORES*DATA_W/8-1:0]    req_be,
    output logic [N_CORES-1:0]             done,
    output logic [N_CORES*DATA_W-1:0]      rdata
);

    localparam int SEL_W = $clog2(N_CORES);
    localparam int ROW_W = ADDR_W - SEL_W;
    localparam int BE_W  = DATA_W / 8;

    logic [SEL_W-1:0]  rot_q;
    logic [SEL_W-1:0]  sel     [N_CORES];
    logic [ROW_W-1:0]  row     [N_CORES];
    logic [DATA_W-1:0] wd      [N_CORES];
    logic [BE_W-1:0]   bem     [N_CORES];
    logic [DATA_W-1:0] bank_rd [N_CORES];

    hub_rotor #(.SEL_W(SEL_W)) u_rotor (
        .clk   (clk),
        .rst_n (rst_n),
        .rot   (rot_q)
    );

    // Per-core side: split the flat buses, decide alignment, hold read data.
    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        assign sel[c] = req_addr[c*ADDR_W +: SEL_W];
        assign row[c] = req_addr[c*ADDR_W + SEL_W +: ROW_W];
        assign wd[c]  = req_wdata[c*DATA_W +: DATA_W];
        assign bem[c] = req_be[c*BE_W +: BE_W];

        hub_grant #(.SEL_W(SEL_W), .CORE_ID(c), .MODE(MODE)) u_grant (
            .rst_n    (rst_n),
            .rot      (rot_q),
            .req      (req_valid[c]),
            .bank_sel (sel[c]),
            .done     (done[c])
        );

        // Capture the bank output at the edge that ends a read's done cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata[c*DATA_W +: DATA_W] <= '0;
            else if (done[c] && !req_we[c])
                rdata[c*DATA_W +: DATA_W] <= bank_rd[sel[c]];
        end
    end

    // Per-bank side: find the core facing this bank and route its access.
    for (genvar b = 0; b < N_CORES; b++) begin : g_bank
        logic [SEL_W-1:0] owner;
        logic             hit;

        // Pick the owning core for this cycle and confirm its access lands here.
        always_comb begin
            if (MODE == hub_pkg::HUB_SLICED) owner = SEL_W'(b) - rot_q;
            else                             owner = rot_q;
            hit = done[owner] && (sel[owner] == SEL_W'(b));
        end

        hub_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .wr_en   (hit && req_we[owner]),
            .be      (bem[owner]),
            .row     (row[owner]),
            .wdata   (wd[owner]),
            .rd_data (bank_rd[b])
        );
    end

endmodule

// File: rtl/hub_rotary_xbar_chk.sv
// Property checker for the rotating crossbar, attached by bind.
// Assumes the same parameters as the instance it watches.
module hub_rotary_xbar_chk #(
    parameter int                 N_CORES = 16,
    parameter int                 ADDR_W  = 10,
    parameter int                 DATA_W  = 32,
    parameter hub_pkg::hub_mode_e MODE    = hub_pkg::HUB_SLICED
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_CORES-1:0]          req_valid,
    input logic [N_CORES-1:0]          req_we,
    input logic [N_CORES*ADDR_W-1:0]   req_addr,
    input logic [N_CORES-1:0]          done,
    input logic [N_CORES*DATA_W-1:0]   rdata,
    input logic [$clog2(N_CORES)-1:0]  rot_q
);

    localparam int SEL_W = $clog2(N_CORES);

    logic [N_CORES-1:0] bank_hits [N_CORES];

    // Group completing cores by the bank their address names.
    always_comb begin
        for (int b = 0; b < N_CORES; b++) begin
            for (int c = 0; c < N_CORES; c++) begin
                bank_hits[b][c] = done[c] &&
                    (req_addr[c*ADDR_W +: SEL_W] == SEL_W'(b));
            end
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (done == '0));

    a_r2_rot_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rot_q == SEL_W'($past(rot_q) + 1'b1)));

    a_r2_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (done & ~req_valid) == '0);

    for (genvar b = 0; b < N_CORES; b++) begin : g_bank_chk
        a_r3_one_core_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(bank_hits[b]) <= 1);
    end

    for (genvar c = 0; c < N_CORES; c++) begin : g_core_chk
        a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(done[c] && !req_we[c]) |-> $stable(rdata[c*DATA_W +: DATA_W]));

        if (MODE == hub_pkg::HUB_SLICED) begin : g_stream
            a_r5_stream_next: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(done[c]) && req_valid[c] &&
                 (req_addr[c*ADDR_W +: ADDR_W] ==
                  ADDR_W'($past(req_addr[c*ADDR_W +: ADDR_W]) + 1'b1)))
                |-> done[c]);
        end
    end

    if (MODE == hub_pkg::HUB_SLOT) begin : g_slot
        a_r8_slot_single: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(done));
    end

endmodule

bind hub_rotary_xbar hub_rotary_xbar_chk #(
    .N_CORES (N_CORES),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MODE    (MODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .done      (done),
    .rdata     (rdata),
    .rot_q     (rot_q)
);

// File: tb/hub_rotary_xbar_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module hub_rotary_xbar_tb;

    localparam int N  = 16;
    localparam int AW = 10;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]    valid = '0;
    logic [N-1:0]    we    = '0;
    logic [AW-1:0]   addr  [N];
    logic [DW-1:0]   wdata [N];
    logic [3:0]      be    [N];

    logic [N*AW-1:0] addr_f;
    logic [N*DW-1:0] wdata_f;
    logic [N*4-1:0]  be_f;
    logic [N-1:0]    done_m, done_s;
    logic [N*DW-1:0] rdata_m, rdata_s;

    int tests = 0;
    int fails = 0;
    logic [3:0] rot_model;

    // Pack the per-core stimulus into flat buses.
    always_comb begin
        for (int c = 0; c < N; c++) begin
            addr_f[c*AW +: AW]  = addr[c];
            wdata_f[c*DW +: DW] = wdata[c];
            be_f[c*4 +: 4]      = be[c];
        end
    end

    // Bench rotation count, derived from the reset and stepping rules.
    always @(posedge clk) rot_model <= rst_n ? rot_model + 4'd1 : 4'd0;

    hub_rotary_xbar #(.N_CORES(N), .ADDR_W(AW), .DATA_W(DW),
                      .MODE(hub_pkg::HUB_SLICED)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(valid), .req_we(we),
        .req_addr(addr_f), .req_wdata(wdata_f), .req_be(be_f),
        .done(done_m), .rdata(rdata_m));

    hub_rotary_xbar #(.N_CORES(N), .ADDR_W(AW), .DATA_W(DW),
                      .MODE(hub_pkg::HUB_SLOT)) u_dut_slot (
        .clk(clk), .rst_n(rst_n), .req_valid(valid), .req_we(we),
        .req_addr(addr_f), .req_wdata(wdata_f), .req_be(be_f),
        .done(done_s), .rdata(rdata_s));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int wait_sliced(input int c, input int bank, input int rot);
        return ((bank - c - rot) % 16 + 32) % 16;
    endfunction

    function automatic int wait_slot(input int c, input int rot);
        return ((c - rot) % 16 + 32) % 16;
    endfunction

    // Issue one access from core c at a negedge; return cycles waited and read data.
    task automatic access(input int c, input bit w, input logic [AW-1:0] a,
                          input logic [31:0] d, input logic [3:0] m, input bit slot,
                          output int waited, output logic [31:0] rd);
        valid[c] = 1'b1; we[c] = w; addr[c] = a; wdata[c] = d; be[c] = m;
        #1;
        waited = 0;
        while (!(slot ? done_s[c] : done_m[c]) && waited < 40) begin
            @(posedge clk); @(negedge clk);
            waited++;
        end
        @(posedge clk); @(negedge clk);
        valid[c] = 1'b0;
        rd = slot ? rdata_s[c*DW +: DW] : rdata_m[c*DW +: DW];
    endtask

    task automatic t_reset;
        int w; logic [31:0] rd;
        valid = '1;
        for (int c = 0; c < N; c++) begin addr[c] = AW'(c); we[c] = 1'b0; end
        repeat (3) @(negedge clk);
        #1;
        check("R1 done in reset (sliced)", 32'(done_m), 32'h0);
        check("R1 done in reset (slot)", 32'(done_s), 32'h0);
        check("R1 rdata lane 5 in reset", rdata_m[5*DW +: DW], 32'h0);
        valid = '0;
        rst_n = 1'b1;
        // First cycle after release: rotation 0, core 0 faces bank 0 and owns the slot.
        access(0, 1'b1, 10'h000, 32'hCAFE0000, 4'hF, 1'b0, w, rd);
        check("R1 rotation zero after release (sliced wait)", 32'(w), 32'd0);
    endtask

    task automatic t_latency;
        int cs[4] = '{3, 12, 0, 15};
        int bs[4] = '{5, 2, 15, 0};
        int w, exp; logic [31:0] rd;
        for (int i = 0; i < 4; i++) begin
            repeat (i + 2) @(negedge clk);
            exp = wait_sliced(cs[i], bs[i], int'(rot_model));
            access(cs[i], 1'b0, AW'(16 * (i + 1) + bs[i]), 32'h0, 4'h0, 1'b0, w, rd);
            check($sformatf("R2 wait core %0d bank %0d", cs[i], bs[i]), 32'(w), 32'(exp));
        end
    endtask

    task automatic t_gaps;
        int w; logic [31:0] rd;
        access(7, 1'b0, 10'h011, 32'h0, 4'h0, 1'b0, w, rd);
        access(7, 1'b0, 10'h015, 32'h0, 4'h0, 1'b0, w, rd);
        check("R4 gap bank 1 to bank 5", 32'(w + 1), 32'd4);
        access(7, 1'b0, 10'h022, 32'h0, 4'h0, 1'b0, w, rd);
        access(7, 1'b0, 10'h02C, 32'h0, 4'h0, 1'b0, w, rd);
        check("R4 gap bank 2 to bank 12", 32'(w + 1), 32'd10);
    endtask

    task automatic t_stream;
        int w; logic [31:0] rd;
        for (int i = 0; i < 8; i++) begin
            access(9, 1'b1, AW'(10'h03C + i), 32'h5000 + i, 4'hF, 1'b0, w, rd);
            if (i > 0) check($sformatf("R5 write stream step %0d wait", i), 32'(w), 32'd0);
        end
        for (int i = 0; i < 8; i++) begin
            access(2, 1'b0, AW'(10'h03C + i), 32'h0, 4'h0, 1'b0, w, rd);
            if (i > 0) check($sformatf("R5 read stream step %0d wait", i), 32'(w), 32'd0);
            check($sformatf("R9 R6 streamed word %0d via other core", i), rd, 32'h5000 + i);
        end
    endtask

    task automatic t_byte_en;
        int w; logic [31:0] rd;
        access(1, 1'b1, 10'h081, 32'hFFFFFFFF, 4'hF, 1'b0, w, rd);
        access(1, 1'b1, 10'h081, 32'h11223344, 4'b0101, 1'b0, w, rd);
        access(1, 1'b0, 10'h081, 32'h0, 4'h0, 1'b0, w, rd);
        check("R7 partial byte mask", rd, 32'hFF22FF44);
        access(1, 1'b1, 10'h081, 32'h00000000, 4'h0, 1'b0, w, rd);
        access(1, 1'b0, 10'h081, 32'h0, 4'h0, 1'b0, w, rd);
        check("R7 empty mask leaves word", rd, 32'hFF22FF44);
        // Read lane keeps its value through a write completing on the same core.
        access(1, 1'b1, 10'h091, 32'h12345678, 4'hF, 1'b0, w, rd);
        check("R6 rdata held over a write", rd, 32'hFF22FF44);
    endtask

    task automatic t_all_cores;
        logic [N-1:0] got = '0;
        logic [N-1:0] dn;
        int w; logic [31:0] rd;
        for (int c = 0; c < N; c++) begin
            addr[c] = AW'((c << 4) | 6); wdata[c] = 32'hA000 + c; be[c] = 4'hF; we[c] = 1'b1;
        end
        valid = '1;
        for (int k = 0; k < N; k++) begin
            valid = valid & ~got;
            #1;
            dn = done_m;
            check($sformatf("R3 single owner of bank 6, cycle %0d", k), 32'($countones(dn) <= 1), 32'd1);
            got = got | dn;
            @(posedge clk); @(negedge clk);
        end
        valid = '0;
        check("R3 every core served within one turn", 32'(got), 32'h0000FFFF);
        access(5, 1'b0, 10'h036, 32'h0, 4'h0, 1'b0, w, rd);
        check("R9 word from core 3 read by core 5", rd, 32'hA003);
    endtask

    task automatic t_slot;
        int w, exp; logic [31:0] rd;
        exp = wait_slot(4, int'(rot_model));
        access(4, 1'b1, 10'h3A7, 32'hBEEF0004, 4'hF, 1'b1, w, rd);
        check("R8 slot wait core 4", 32'(w), 32'(exp));
        access(4, 1'b0, 10'h3A7, 32'h0, 4'h0, 1'b1, w, rd);
        check("R8 slot back-to-back gap", 32'(w + 1), 32'd16);
        check("R8 slot read data", rd, 32'hBEEF0004);
        repeat (3) @(negedge clk);
        exp = wait_slot(11, int'(rot_model));
        access(11, 1'b0, 10'h3A7, 32'h0, 4'h0, 1'b1, w, rd);
        check("R8 slot wait core 11 address-blind", 32'(w), 32'(exp));
        check("R8 R9 slot data shared across cores", rd, 32'hBEEF0004);
    endtask

    initial begin
        for (int c = 0; c < N; c++) begin
            addr[c] = '0; wdata[c] = '0; be[c] = '0;
        end
        @(negedge clk);
        t_reset();
        t_latency();
        t_gaps();
        t_stream();
        t_byte_en();
        t_all_cores();
        t_slot();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule